// File: doc/BRIEF.md
# Right-to-Left Scalar Multiplication Controller

This block sequences the computation of kP, the point P added to itself k times, for a KW-bit scalar k and an affine base point P. It scans k from the least significant bit upward. It holds three pieces of state: an accumulator point Q, a running multiple R of P, and a shift register for the scalar. It does no field arithmetic of its own. Two external point units do that work: an adder that forms Q + R and a doubler that forms 2R. Each step launches both units in the same cycle, so the addition and the doubling overlap in time. A step commits only after every unit it launched has reported completion.

Latency is the aim. The controller launches no unit whose work would be wasted. When Q is still the point at infinity, Q + R is just R, so a copy takes the place of the addition. When R is infinity, the addition is skipped (Q + O = Q) and so is the doubling (2·O = O). When no set bits remain above the current one, no doubling is launched. The scan ends as soon as the remaining scalar is zero. A one-cycle done pulse marks the result, which stays on the outputs until the next start.

Top module: `smul_ctrl`

## Requirements
- R1: A start pulse while busy is low captures k and P, and busy is high from the next cycle until the done cycle. A start while busy is high is ignored and has no effect on the result.
- R2: At done, q_inf is 0 and qx/qy hold the point kP as produced by chained calls to the point units, for every nonzero k when P is finite.
- R3: When k is zero or p_inf is 1 at start, no unit is launched, q_inf is 1, and done is asserted exactly two clock cycles after the cycle in which start is presented.
- R4: The adder is launched only for a set scalar bit when both Q and R are finite, so add_a_inf and add_b_inf are 0 whenever add_go is 1. The lowest set bit copies R into Q without a launch, so the adder runs popcount(k)−1 times.
- R5: The doubler is launched in a step only while scalar bits above the current bit are nonzero, so it runs exactly as many times as the bit position of the highest set bit of k.
- R6: When a step needs both units, add_go and dbl_go are pulsed in the same cycle. The step commits only after both add_done and dbl_done have been seen, in either order or together. Only the step for the highest set bit launches the adder alone.
- R7: done is a single-cycle pulse with busy low. While busy is low and no start is presented, qx, qy and q_inf do not change.
- R8: add_go and dbl_go are single-cycle pulses and are never high while busy is low.
- R9: After reset, busy, done, add_go and dbl_go are 0 and q_inf is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication (accepted when idle) |
| k | input | KW | Scalar |
| px | input | FW | Base point x |
| py | input | FW | Base point y |
| p_inf | input | 1 | Base point is infinity |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle completion pulse |
| qx | output | FW | Result x |
| qy | output | FW | Result y |
| q_inf | output | 1 | Result is infinity |
| add_go | output | 1 | Launch pulse to the adder |
| add_ax | output | FW | Adder operand A x (accumulator) |
| add_ay | output | FW | Adder operand A y |
| add_a_inf | output | 1 | Adder operand A infinity flag |
| add_bx | output | FW | Adder operand B x (running multiple) |
| add_by | output | FW | Adder operand B y |
| add_b_inf | output | 1 | Adder operand B infinity flag |
| add_done | input | 1 | Adder completion pulse |
| add_rx | input | FW | Adder result x |
| add_ry | input | FW | Adder result y |
| add_r_inf | input | 1 | Adder result infinity flag |
| dbl_go | output | 1 | Launch pulse to the doubler |
| dbl_x | output | FW | Doubler operand x |
| dbl_y | output | FW | Doubler operand y |
| dbl_inf | output | 1 | Doubler operand infinity flag |
| dbl_done | input | 1 | Doubler completion pulse |
| dbl_rx | input | FW | Doubler result x |
| dbl_ry | input | FW | Doubler result y |
| dbl_r_inf | input | 1 | Doubler result infinity flag |

## Verification
The result of a nonzero scalar arrives a data-dependent number of cycles after start, because the bench point units answer after a random delay of one to four cycles. For that reason each check waits on the done pulse, sampled at the falling edge, and compares the result in that cycle. The zero-scalar and infinite-point cases have a fixed latency of two cycles from the cycle start is driven, and a scalar of one takes three. The bench counts falling edges to check those exactly. Launch counts, and the cycles where the adder is launched without the doubler, are tallied at the falling edge as the pulses appear. Result hold is checked several cycles after done.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2
  } smul_state_e;
endpackage

// File: rtl/smul_scalar.sv
module smul_scalar #(
  parameter int KW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          force_zero,
  input  logic [KW-1:0] k_in,
  input  logic          shift,
  output logic          cur_bit,
  output logic          upper_nz,
  output logic          all_zero
);
  logic [KW-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (load) begin
      sreg <= force_zero ? '0 : k_in;
    end else if (shift) begin
      sreg <= {1'b0, sreg[KW-1:1]};
    end
  end

  assign cur_bit  = sreg[0];
  assign upper_nz = |sreg[KW-1:1];
  assign all_zero = (sreg == '0);
endmodule

// File: rtl/smul_ptreg.sv
module smul_ptreg #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_inf,
  input  logic          load,
  input  logic [FW-1:0] d_x,
  input  logic [FW-1:0] d_y,
  input  logic          d_inf,
  output logic [FW-1:0] x,
  output logic [FW-1:0] y,
  output logic          inf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      x   <= '0;
      y   <= '0;
      inf <= 1'b1;
    end else if (set_inf) begin
      x   <= '0;
      y   <= '0;
      inf <= 1'b1;
    end else if (load) begin
      x   <= d_x;
      y   <= d_y;
      inf <= d_inf;
    end
  end
endmodule

// File: rtl/smul_seq.sv
module smul_seq
  import smul_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic all_zero,
  input  logic cur_bit,
  input  logic upper_nz,
  input  logic q_inf,
  input  logic r_inf,
  input  logic add_done,
  input  logic dbl_done,
  output logic accept,
  output logic shift,
  output logic q_load,
  output logic q_sel_add,
  output logic r_load,
  output logic add_go,
  output logic dbl_go,
  output logic busy,
  output logic done
);
  smul_state_e state;
  logic pend_add, pend_dbl, pend_copy;
  logic got_add, got_dbl;
  logic need_add, need_dbl, need_copy;
  logic fin_add, fin_dbl, step_end;

  always_comb begin
    need_add  = cur_bit && !q_inf && !r_inf;
    need_copy = cur_bit && q_inf && !r_inf;
    need_dbl  = upper_nz && !r_inf;
    fin_add   = !pend_add || got_add || add_done;
    fin_dbl   = !pend_dbl || got_dbl || dbl_done;
    step_end  = (state == ST_WAIT) && fin_add && fin_dbl;
  end

  always_comb begin
    accept    = (state == ST_IDLE) && start;
    shift     = 1'b0;
    q_load    = 1'b0;
    q_sel_add = 1'b0;
    r_load    = 1'b0;
    if (state == ST_SCAN && !all_zero && !need_add && !need_dbl) begin
      shift  = 1'b1;
      q_load = need_copy;
    end else if (step_end) begin
      shift     = 1'b1;
      q_load    = pend_add || pend_copy;
      q_sel_add = pend_add;
      r_load    = pend_dbl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend_add  <= 1'b0;
      pend_dbl  <= 1'b0;
      pend_copy <= 1'b0;
      got_add   <= 1'b0;
      got_dbl   <= 1'b0;
      add_go    <= 1'b0;
      dbl_go    <= 1'b0;
      done      <= 1'b0;
    end else begin
      add_go <= 1'b0;
      dbl_go <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) state <= ST_SCAN;
        end
        ST_SCAN: begin
          if (all_zero) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (need_add || need_dbl) begin
            add_go    <= need_add;
            dbl_go    <= need_dbl;
            pend_add  <= need_add;
            pend_dbl  <= need_dbl;
            pend_copy <= need_copy;
            got_add   <= 1'b0;
            got_dbl   <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (step_end) begin
            state <= ST_SCAN;
          end else begin
            got_add <= got_add || add_done;
            got_dbl <= got_dbl || dbl_done;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
  parameter int KW = 12,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [KW-1:0] k,
  input  logic [FW-1:0] px,
  input  logic [FW-1:0] py,
  input  logic          p_inf,
  output logic          busy,
  output logic          done,
  output logic [FW-1:0] qx,
  output logic [FW-1:0] qy,
  output logic          q_inf,
  output logic          add_go,
  output logic [FW-1:0] add_ax,
  output logic [FW-1:0] add_ay,
  output logic          add_a_inf,
  output logic [FW-1:0] add_bx,
  output logic [FW-1:0] add_by,
  output logic          add_b_inf,
  input  logic          add_done,
  input  logic [FW-1:0] add_rx,
  input  logic [FW-1:0] add_ry,
  input  logic          add_r_inf,
  output logic          dbl_go,
  output logic [FW-1:0] dbl_x,
  output logic [FW-1:0] dbl_y,
  output logic          dbl_inf,
  input  logic          dbl_done,
  input  logic [FW-1:0] dbl_rx,
  input  logic [FW-1:0] dbl_ry,
  input  logic          dbl_r_inf
);
  logic accept, shift, q_load, q_sel_add, r_load;
  logic cur_bit, upper_nz, all_zero;
  logic [FW-1:0] rx, ry;
  logic r_inf;
  logic [FW-1:0] qd_x, qd_y, rd_x, rd_y;
  logic qd_inf, rd_inf, r_wr;

  smul_scalar #(.KW(KW)) u_scalar (
    .clk(clk), .rst(rst), .load(accept), .force_zero(p_inf), .k_in(k),
    .shift(shift), .cur_bit(cur_bit), .upper_nz(upper_nz), .all_zero(all_zero)
  );

  smul_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .all_zero(all_zero), .cur_bit(cur_bit),
    .upper_nz(upper_nz), .q_inf(q_inf), .r_inf(r_inf), .add_done(add_done),
    .dbl_done(dbl_done), .accept(accept), .shift(shift), .q_load(q_load),
    .q_sel_add(q_sel_add), .r_load(r_load), .add_go(add_go), .dbl_go(dbl_go),
    .busy(busy), .done(done)
  );

  always_comb begin
    qd_x   = q_sel_add ? add_rx    : rx;
    qd_y   = q_sel_add ? add_ry    : ry;
    qd_inf = q_sel_add ? add_r_inf : r_inf;
    rd_x   = accept ? px    : dbl_rx;
    rd_y   = accept ? py    : dbl_ry;
    rd_inf = accept ? p_inf : dbl_r_inf;
    r_wr   = accept || r_load;
  end

  smul_ptreg #(.FW(FW)) u_acc (
    .clk(clk), .rst(rst), .set_inf(accept), .load(q_load),
    .d_x(qd_x), .d_y(qd_y), .d_inf(qd_inf), .x(qx), .y(qy), .inf(q_inf)
  );

  smul_ptreg #(.FW(FW)) u_run (
    .clk(clk), .rst(rst), .set_inf(1'b0), .load(r_wr),
    .d_x(rd_x), .d_y(rd_y), .d_inf(rd_inf), .x(rx), .y(ry), .inf(r_inf)
  );

  assign add_ax    = qx;
  assign add_ay    = qy;
  assign add_a_inf = q_inf;
  assign add_bx    = rx;
  assign add_by    = ry;
  assign add_b_inf = r_inf;
  assign dbl_x     = rx;
  assign dbl_y     = ry;
  assign dbl_inf   = r_inf;
endmodule

// File: rtl/smul_ctrl_chk.sv
module smul_ctrl_chk #(
  parameter int KW = 12,
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [KW-1:0] k,
  input logic          p_inf,
  input logic          busy,
  input logic          done,
  input logic [FW-1:0] qx,
  input logic [FW-1:0] qy,
  input logic          q_inf,
  input logic          add_go,
  input logic          add_a_inf,
  input logic          add_b_inf,
  input logic          dbl_go
);
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_zero_fast_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (k == '0 || p_inf)) |=> (busy && !done) ##1 (done && q_inf));

  assert_add_finite_R4: assert property (@(posedge clk) disable iff (rst)
    add_go |-> (!add_a_inf && !add_b_inf));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(qx) && $stable(qy) && $stable(q_inf)));

  assert_add_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    add_go |=> !add_go);

  assert_dbl_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    dbl_go |=> !dbl_go);

  assert_no_go_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!add_go && !dbl_go));
endmodule

bind smul_ctrl smul_ctrl_chk #(.KW(KW), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .k(k), .p_inf(p_inf), .busy(busy),
  .done(done), .qx(qx), .qy(qy), .q_inf(q_inf), .add_go(add_go),
  .add_a_inf(add_a_inf), .add_b_inf(add_b_inf), .dbl_go(dbl_go)
);

// File: tb/smul_ctrl_test.sv
module smul_ctrl_test;
  localparam int KW = 12;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [KW-1:0] k = '0;
  logic [FW-1:0] px = '0, py = '0;
  logic p_inf = 1'b0;
  logic busy, done, q_inf, add_go, add_a_inf, add_b_inf, dbl_go, dbl_inf;
  logic [FW-1:0] qx, qy, add_ax, add_ay, add_bx, add_by, dbl_x, dbl_y;
  logic add_done = 1'b0, dbl_done = 1'b0;
  logic [FW-1:0] add_rx = '0, add_ry = '0, dbl_rx = '0, dbl_ry = '0;
  logic add_r_inf = 1'b0, dbl_r_inf = 1'b0;

  int checks = 0, fails = 0;
  int add_cnt = 0, dbl_cnt = 0, add_only = 0, bad_op = 0;
  int add_wait = 0, dbl_wait = 0;

  always #2.5 clk = ~clk;

  smul_ctrl #(.KW(KW), .FW(FW)) uut (.*);

  // Point unit models in a toy additive group: value v, infinity iff v==0, y = ~v.
  always @(negedge clk) begin
    add_done <= 1'b0;
    dbl_done <= 1'b0;
    if (add_go) begin
      add_cnt++;
      if (!dbl_go) add_only++;
      if (add_a_inf || add_b_inf) bad_op++;
      add_rx    <= add_ax + add_bx;
      add_ry    <= ~(add_ax + add_bx);
      add_r_inf <= ((add_ax + add_bx) == '0);
      add_wait  <= 1 + int'($urandom % 4);
    end else if (add_wait > 0) begin
      if (add_wait == 1) add_done <= 1'b1;
      add_wait <= add_wait - 1;
    end
    if (dbl_go) begin
      dbl_cnt++;
      dbl_rx    <= dbl_x << 1;
      dbl_ry    <= ~(dbl_x << 1);
      dbl_r_inf <= ((dbl_x << 1) == '0);
      dbl_wait  <= 1 + int'($urandom % 4);
    end else if (dbl_wait > 0) begin
      if (dbl_wait == 1) dbl_done <= 1'b1;
      dbl_wait <= dbl_wait - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [KW-1:0] v);
    int n = 0;
    for (int i = 0; i < KW; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int msb_pos(input logic [KW-1:0] v);
    int p = 0;
    for (int i = 0; i < KW; i++) if (v[i]) p = i;
    return p;
  endfunction

  // Runs one multiplication; returns cycles from start drive to done.
  task automatic run(input logic [KW-1:0] kv, input logic [FW-1:0] pv, input logic pinf,
                     input bit poke, output int lat);
    logic [FW-1:0] ev;
    lat = 0;
    add_cnt = 0; dbl_cnt = 0; add_only = 0; bad_op = 0;
    k = kv; px = pv; py = ~pv; p_inf = pinf; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = ~kv; px = ~pv;
    lat = 1;
    while (!done && lat < 2000) begin
      if (poke && lat == 4) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    ev = FW'(kv) * pv;
    if (!done) chk(1'b0, "watchdog", 0, 1);
    if (kv == '0 || pinf) begin
      chk(q_inf == 1'b1, "R3 result inf", q_inf, 1);
      chk(lat == 2, "R3 latency", lat, 2);
      chk(add_cnt + dbl_cnt == 0, "R3 no launch", add_cnt + dbl_cnt, 0);
    end else begin
      chk(q_inf == 1'b0, "R2 q_inf", q_inf, 0);
      chk(qx == ev, "R2 qx", qx, ev);
      chk(qy == ~ev, "R2 qy", qy, ~ev);
      chk(add_cnt == popc(kv) - 1, "R4 add count", add_cnt, popc(kv) - 1);
      chk(bad_op == 0, "R4 inf operand", bad_op, 0);
      chk(dbl_cnt == msb_pos(kv), "R5 dbl count", dbl_cnt, msb_pos(kv));
      chk(add_only == ((popc(kv) >= 2) ? 1 : 0), "R6 add-only steps", add_only,
          (popc(kv) >= 2) ? 1 : 0);
    end
    chk(busy == 1'b0, "R7 busy at done", busy, 0);
  endtask

  initial begin
    int lat;
    logic [FW-1:0] hx;
    void'($urandom(32'h5EED_0C1A));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busy == 0 && done == 0 && add_go == 0 && dbl_go == 0, "R9 reset ctrl", busy, 0);
    chk(q_inf == 1'b1, "R9 reset q_inf", q_inf, 1);
    rst = 1'b0;
    @(negedge clk);

    run('0, 16'h0003, 1'b0, 1'b0, lat);        // R3 zero scalar
    run(12'h0A5, 16'h0011, 1'b1, 1'b0, lat);   // R3 infinite base point
    run(12'h001, 16'h1235, 1'b0, 1'b0, lat);   // R4 copy only
    chk(lat == 3, "R4 k=1 latency", lat, 3);
    run(12'hFFF, 16'h0007, 1'b0, 1'b0, lat);   // R6 all bits set
    run(12'h800, 16'h00FF, 1'b0, 1'b0, lat);   // R5 only top bit
    run(12'h801, 16'h4321, 1'b0, 1'b0, lat);   // R2 ends
    run(12'h3C5, 16'h2469, 1'b0, 1'b1, lat);   // R1 start while busy ignored
    chk(qx == FW'(FW'(12'h3C5) * 16'h2469), "R1 ignored start", qx, FW'(12'h3C5) * 16'h2469);

    // R7 hold after done
    hx = qx;
    repeat (6) @(negedge clk);
    chk(qx == hx && done == 1'b0, "R7 hold", qx, hx);

    for (int i = 0; i < 40; i++) begin
      logic [KW-1:0] kr;
      logic [FW-1:0] pr;
      kr = KW'($urandom);
      pr = FW'($urandom) | 16'h0001;
      run(kr, pr, 1'b0, 1'b0, lat);
      repeat (int'($urandom % 3)) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule